// File: doc/BRIEF.md
# Scheduled Crossbar Instruction Sequencer

Each tile of a streaming on-chip network routes data through a five-way crossbar with the ports north, south, east, west and the local core. This block controls that crossbar from a small, statically compiled program. Each communication cycle it runs one entry of a sixteen-entry instruction store. A route entry sets, for every output port, which input port feeds it, and it tags the transfer with a stream number. A branch-always entry closes the schedule and sends it back to an earlier entry, so the time-slice pattern repeats. A branch-if-equal entry compares a data word from the core with a constant and can redirect the schedule while it runs.

Software loads the program through a configuration write port while the run enable is low. Raising the run enable starts the schedule at entry 0. A stall from the flow-control logic freezes the schedule and the crossbar selects for as long as it is asserted. The crossbar datapath and the stream buffers lie outside this block. They take the registered selects, the valid flag and the stream number from it.

Top module: `xbar_sched_seq`

## Requirements
- R1: While reset (rst_n low) is held and on the first cycle after it, xfer_valid_o is 0, stream_id_o is 0 and every 3-bit select in xbar_sel_o is 7, the idle code.
- R2: An instruction word is 24 bits. Bits [1:0] hold the opcode (0 route, 1 branch-always, 2 branch-if-equal, 3 acts as branch-always). Bits [16:2] hold five 3-bit selects, with output port p at bits [2+3p +: 3]; a select names input port 0 to 4 as source, and codes 5 to 7 mean no source. Bits [19:17] hold the stream id and bits [23:20] hold the branch target. A route entry that runs at a clock edge puts its selects on xbar_sel_o (with select codes 5 and 6 output as 7), puts its stream id on stream_id_o and sets xfer_valid_o to 1 after that edge. The next entry is then the following one.
- R3: A branch-always entry runs in one cycle and makes no transfer: after its edge xfer_valid_o is 0, stream_id_o is 0 and all selects are 7. The next entry is its target.
- R4: A branch-if-equal entry compares test_data_i with the low 8 bits of its select field (bits [9:2] of the word). On a match the next entry is the target, otherwise the following entry. The outputs behave as in R3.
- R5: While stall_i is high, the entry pointer and all outputs hold their values. When stall_i falls, the schedule resumes with the entry it would have run next.
- R6: A write with cfg_we_i high stores cfg_wdata_i at cfg_addr_i only while run_en_i is low. A write while run_en_i is high leaves the store unchanged.
- R7: While run_en_i is low the outputs go idle (as in R1) after the next edge and the entry pointer returns to 0. The first edge with run_en_i high arms the schedule, and entry 0 runs at the following edge.
- R8: A route entry at the last address (15) is followed by entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en_i | input | 1 | Schedule run enable; low allows loading |
| cfg_we_i | input | 1 | Instruction store write strobe |
| cfg_addr_i | input | 4 | Instruction store write address |
| cfg_wdata_i | input | 24 | Instruction word to store |
| test_data_i | input | 8 | Core data word tested by conditional branches |
| stall_i | input | 1 | Flow-control stall; freezes the schedule |
| xbar_sel_o | output | 15 | Five 3-bit source selects, port p at [3p +: 3], 7 = idle |
| xfer_valid_o | output | 1 | A route entry drives the crossbar this cycle |
| stream_id_o | output | 3 | Stream number of the current transfer |

## Verification
On every cycle the assertions check that the entry pointer steps by one after a route and lands on the target after a branch-always. They also check that branch entries and a low run enable leave the crossbar idle, that a stall freezes both the pointer and the outputs, and that a write during a run leaves the store unchanged. Only the bench scenarios can show the full time-slice order of a looping schedule: the repeat after the closing branch, both outcomes of the data test against the core word, where the schedule resumes after a stall or a restart, and the wrap from the last address. They also show that a program keeps its old contents when a write arrives mid-run.

// File: rtl/xss_pkg.sv
// Package: shared opcode type for the scheduled crossbar sequencer.
// Assumes a 2-bit opcode at the bottom of every instruction word.
package xss_pkg;

    typedef enum logic [1:0] {
        OP_ROUTE = 2'd0,
        OP_JUMP  = 2'd1,
        OP_BEQ   = 2'd2,
        OP_RSVD  = 2'd3
    } xss_op_e;

    localparam int unsigned OP_W = 2;

endpackage

// File: rtl/xss_imem.sv
// Module: instruction store for the schedule.
// Holds DEPTH words of IW bits. One write port, accepted only while the
// schedule is stopped. One asynchronous read port addressed by the
// entry pointer. Assumes the writer keeps cfg_addr_i within DEPTH.
module xss_imem #(
    parameter int unsigned AW = 4,
    parameter int unsigned IW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en_i,
    input  logic          cfg_we_i,
    input  logic [AW-1:0] cfg_addr_i,
    input  logic [IW-1:0] cfg_wdata_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [IW-1:0] rd_data_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [IW-1:0] mem_q [DEPTH];

    // Store a configuration word while the schedule is stopped.
    always_ff @(posedge clk) begin
        if (cfg_we_i && !run_en_i) begin
            mem_q[cfg_addr_i] <= cfg_wdata_i;
        end
    end

    // Present the entry selected by the pointer.
    assign rd_data_o = mem_q[rd_addr_i];

    // R6: a write while running leaves the addressed word untouched.
    p_locked_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && run_en_i) |=> (mem_q[$past(cfg_addr_i)] == $past(mem_q[cfg_addr_i])));

endmodule

// File: rtl/xss_pc_ctrl.sv
// Module: entry pointer and next-entry logic.
// Arms on the first edge with run_en_i high and runs one entry per edge
// after that, unless stalled. Route entries step by one (wrapping through
// the address width). Branch-always goes to the target, and
// branch-if-equal goes to the target when the core word matches its
// constant. Assumes the decoded fields belong to the entry at pc_o.
module xss_pc_ctrl #(
    parameter int unsigned AW     = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en_i,
    input  logic              stall_i,
    input  xss_pkg::xss_op_e  op_i,
    input  logic [AW-1:0]     target_i,
    input  logic [DATA_W-1:0] cmp_i,
    input  logic [DATA_W-1:0] test_data_i,
    output logic [AW-1:0]     pc_o,
    output logic              exec_o
);
    import xss_pkg::*;

    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_nxt;
    logic          armed_q;
    logic [AW-1:0] pc_inc;

    assign pc_inc = pc_q + AW'(1);

    // Choose the entry that follows the one now running.
    always_comb begin
        unique case (op_i)
            OP_ROUTE: pc_nxt = pc_inc;
            OP_BEQ:   pc_nxt = (test_data_i == cmp_i) ? target_i : pc_inc;
            default:  pc_nxt = target_i;
        endcase
    end

    // An entry runs when armed, enabled and not stalled.
    assign exec_o = armed_q && run_en_i && !stall_i;

    // Track arming and advance the pointer one entry per executing edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en_i) begin
            pc_q    <= '0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (exec_o) begin
                pc_q <= pc_nxt;
            end
        end
    end

    assign pc_o = pc_q;

    // R7: a stopped schedule points at entry 0.
    p_pc_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> (pc_o == '0));

    // R5: a stall freezes the pointer.
    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_i && stall_i) |=> $stable(pc_o));

    // R2: a route entry advances the pointer by one.
    p_route_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && op_i == OP_ROUTE) |=> (pc_o == $past(pc_o) + AW'(1)));

    // R3: branch-always lands on its target.
    p_jump_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && op_i == OP_JUMP) |=> (pc_o == $past(target_i)));

endmodule

// File: rtl/xss_out_stage.sv
// Module: registered crossbar control outputs.
// Maps out-of-range select codes to the idle code, one lane per output
// port. It loads the route entry's selects and stream id on an executing
// route and drives idle on branch entries and while stopped. It holds
// everything on any other cycle (stall, arming). Assumes the idle code is
// all ones of SEL_W.
module xss_out_stage #(
    parameter int unsigned NPORT = 5,
    parameter int unsigned SEL_W = 3,
    parameter int unsigned SID_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_en_i,
    input  logic                   exec_i,
    input  logic                   is_route_i,
    input  logic [NPORT*SEL_W-1:0] sel_i,
    input  logic [SID_W-1:0]       sid_i,
    output logic [NPORT*SEL_W-1:0] sel_o,
    output logic                   valid_o,
    output logic [SID_W-1:0]       sid_o
);
    localparam int unsigned      SELS_W   = NPORT * SEL_W;
    localparam logic [SEL_W-1:0] IDLE     = '1;
    localparam logic [SEL_W-1:0] NP_CODE  = SEL_W'(NPORT);
    localparam logic [SELS_W-1:0] IDLE_ALL = '1;

    logic [SELS_W-1:0] sel_clean;
    logic [SELS_W-1:0] sel_q;
    logic              valid_q;
    logic [SID_W-1:0]  sid_q;

    // One lane per output port: codes beyond the port count become idle.
    for (genvar p = 0; p < NPORT; p++) begin : g_lane
        assign sel_clean[p*SEL_W +: SEL_W] =
            (sel_i[p*SEL_W +: SEL_W] < NP_CODE) ? sel_i[p*SEL_W +: SEL_W] : IDLE;
    end

    // Register the crossbar control for the next communication cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en_i) begin
            sel_q   <= IDLE_ALL;
            valid_q <= 1'b0;
            sid_q   <= '0;
        end else if (exec_i) begin
            if (is_route_i) begin
                sel_q   <= sel_clean;
                valid_q <= 1'b1;
                sid_q   <= sid_i;
            end else begin
                sel_q   <= IDLE_ALL;
                valid_q <= 1'b0;
                sid_q   <= '0;
            end
        end
    end

    assign sel_o   = sel_q;
    assign valid_o = valid_q;
    assign sid_o   = sid_q;

    // R3: branch entries leave the crossbar idle.
    p_branch_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !is_route_i) |=> (!valid_o && sel_o == IDLE_ALL));

    // R7: a stopped schedule drives no transfer.
    p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> (!valid_o && sel_o == IDLE_ALL && sid_o == '0));

    // R5: a non-executing cycle while enabled holds the outputs.
    p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_i && !exec_i) |=> ($stable(sel_o) && $stable(valid_o) && $stable(sid_o)));

    // R2: a route entry always produces a valid transfer.
    p_route_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && is_route_i) |=> valid_o);

endmodule

// File: rtl/xbar_sched_seq.sv
// Module: scheduled crossbar instruction sequencer (top).
// Ties the instruction store, the entry-pointer control and the output
// register together and splits the instruction word into its fields.
// Word layout, from bit 0: opcode, NPORT selects, stream id, target.
// Assumes DATA_W does not exceed the width of the select field.
module xbar_sched_seq #(
    parameter int unsigned NPORT  = 5,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned SID_W  = 3,
    parameter int unsigned AW     = 4,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SELS_W  = NPORT * SEL_W,
    localparam int unsigned SEL_OFF = xss_pkg::OP_W,
    localparam int unsigned SID_OFF = SEL_OFF + SELS_W,
    localparam int unsigned TGT_OFF = SID_OFF + SID_W,
    localparam int unsigned IW      = TGT_OFF + AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en_i,
    input  logic              cfg_we_i,
    input  logic [AW-1:0]     cfg_addr_i,
    input  logic [IW-1:0]     cfg_wdata_i,
    input  logic [DATA_W-1:0] test_data_i,
    input  logic              stall_i,
    output logic [SELS_W-1:0] xbar_sel_o,
    output logic              xfer_valid_o,
    output logic [SID_W-1:0]  stream_id_o
);
    import xss_pkg::*;

    logic [AW-1:0]     pc;
    logic [IW-1:0]     instr;
    logic              exec;
    xss_op_e           op;
    logic [SELS_W-1:0] f_sel;
    logic [SID_W-1:0]  f_sid;
    logic [AW-1:0]     f_tgt;
    logic [DATA_W-1:0] f_cmp;

    // Split the running entry into its fields.
    assign op    = xss_op_e'(instr[OP_W-1:0]);
    assign f_sel = instr[SEL_OFF +: SELS_W];
    assign f_sid = instr[SID_OFF +: SID_W];
    assign f_tgt = instr[TGT_OFF +: AW];
    assign f_cmp = f_sel[DATA_W-1:0];

    xss_imem #(
        .AW (AW),
        .IW (IW)
    ) imem_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en_i    (run_en_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .rd_addr_i   (pc),
        .rd_data_o   (instr)
    );

    xss_pc_ctrl #(
        .AW     (AW),
        .DATA_W (DATA_W)
    ) pc_ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en_i    (run_en_i),
        .stall_i     (stall_i),
        .op_i        (op),
        .target_i    (f_tgt),
        .cmp_i       (f_cmp),
        .test_data_i (test_data_i),
        .pc_o        (pc),
        .exec_o      (exec)
    );

    xss_out_stage #(
        .NPORT (NPORT),
        .SEL_W (SEL_W),
        .SID_W (SID_W)
    ) out_stage_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en_i   (run_en_i),
        .exec_i     (exec),
        .is_route_i (op == OP_ROUTE),
        .sel_i      (f_sel),
        .sid_i      (f_sid),
        .sel_o      (xbar_sel_o),
        .valid_o    (xfer_valid_o),
        .sid_o      (stream_id_o)
    );

    // R1: leaving reset, the crossbar is idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!xfer_valid_o && xbar_sel_o == '1 && stream_id_o == '0));

endmodule

// File: tb/xbar_sched_seq_tb_top.sv
// Directed bench for the scheduled crossbar sequencer: one task per
// scenario, each checking its own results at the falling clock edge.
module xbar_sched_seq_tb_top;

    localparam logic [14:0] IDLE_SEL = 15'h7FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic [7:0]  test_data = '0;
    logic        stall = 1'b0;
    logic [14:0] xbar_sel;
    logic        xfer_valid;
    logic [2:0]  stream_id;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    xbar_sched_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en_i     (run_en),
        .cfg_we_i     (cfg_we),
        .cfg_addr_i   (cfg_addr),
        .cfg_wdata_i  (cfg_wdata),
        .test_data_i  (test_data),
        .stall_i      (stall),
        .xbar_sel_o   (xbar_sel),
        .xfer_valid_o (xfer_valid),
        .stream_id_o  (stream_id)
    );

    // ---- instruction builders (layout from R2) ----
    function automatic logic [14:0] pk(input int a, input int b, input int c,
                                       input int d, input int e);
        return {3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
    endfunction

    function automatic logic [23:0] w_route(input logic [14:0] s, input logic [2:0] id);
        return {4'd0, id, s, 2'd0};
    endfunction

    function automatic logic [23:0] w_jump(input logic [3:0] t);
        return {t, 3'd0, 15'd0, 2'd1};
    endfunction

    function automatic logic [23:0] w_beq(input logic [7:0] k, input logic [3:0] t);
        return {t, 3'd0, {7'd0, k}, 2'd2};
    endfunction

    // Expected output select: codes 5 and 6 shown as idle.
    function automatic logic [14:0] clean(input logic [14:0] s);
        logic [14:0] r;
        for (int p = 0; p < 5; p++) begin
            r[p*3 +: 3] = (s[p*3 +: 3] > 3'd4) ? 3'd7 : s[p*3 +: 3];
        end
        return r;
    endfunction

    // ---- checking ----
    task automatic check(input string req, input logic [18:0] exp);
        logic [18:0] got;
        got = {xfer_valid, stream_id, xbar_sel};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid/sid/sel=%h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [18:0] e_rt(input logic [14:0] s, input logic [2:0] id);
        return {1'b1, id, clean(s)};
    endfunction

    localparam logic [18:0] E_IDLE = {1'b0, 3'd0, IDLE_SEL};

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load(input logic [3:0] a, input logic [23:0] w);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic start();
        run_en = 1'b1;
        tick();            // arming edge
    endtask

    task automatic stop();
        run_en = 1'b0;
        tick();
    endtask

    // Selects used by the programs.
    localparam logic [14:0] SA = {3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
    localparam logic [14:0] SB = {3'd0, 3'd1, 3'd7, 3'd3, 3'd4};
    localparam logic [14:0] SC = {3'd1, 3'd0, 3'd4, 3'd2, 3'd3};
    localparam logic [14:0] SD = {3'd2, 3'd7, 3'd0, 3'd6, 3'd5};
    localparam logic [14:0] SE = {3'd3, 3'd3, 3'd1, 3'd1, 3'd4};

    // ---- scenarios ----
    task automatic t_reset();
        tick();
        check("R1 during reset", E_IDLE);
        rst_n = 1'b1;
        tick();
        check("R1 after reset", E_IDLE);
    endtask

    task automatic t_loop();
        load(4'd0, w_route(SA, 3'd1));
        load(4'd1, w_route(SB, 3'd2));
        load(4'd2, w_jump(4'd0));
        check("R7 idle while loading", E_IDLE);
        start();
        check("R7 arming edge stays idle", E_IDLE);
        tick(); check("R2 entry0 route", e_rt(SA, 3'd1));
        tick(); check("R2 entry1 route", e_rt(SB, 3'd2));
        tick(); check("R3 jump idle", E_IDLE);
        tick(); check("R3 jump back to entry0", e_rt(SA, 3'd1));
        tick(); check("R2 second pass entry1", e_rt(SB, 3'd2));
        stop();
        check("R7 stop goes idle", E_IDLE);
    endtask

    task automatic t_stall();
        start();
        tick(); check("R5 before stall", e_rt(SA, 3'd1));
        stall = 1'b1;
        tick(); check("R5 stall hold 1", e_rt(SA, 3'd1));
        tick(); check("R5 stall hold 2", e_rt(SA, 3'd1));
        tick(); check("R5 stall hold 3", e_rt(SA, 3'd1));
        stall = 1'b0;
        tick(); check("R5 resume next entry", e_rt(SB, 3'd2));
        tick(); check("R5 resume then jump", E_IDLE);
        stop();
    endtask

    task automatic t_beq();
        load(4'd0, w_route(SC, 3'd3));
        load(4'd1, w_beq(8'h5A, 4'd3));
        load(4'd2, w_route(SD, 3'd4));
        load(4'd3, w_route(SE, 3'd5));
        load(4'd4, w_jump(4'd0));
        test_data = 8'h5A;
        start();
        tick(); check("R4 taken: entry0", e_rt(SC, 3'd3));
        tick(); check("R4 taken: branch idle", E_IDLE);
        tick(); check("R4 taken: lands on target", e_rt(SE, 3'd5));
        tick(); check("R4 taken: closing jump", E_IDLE);
        tick(); check("R4 taken: loop", e_rt(SC, 3'd3));
        stop();
        test_data = 8'h11;
        start();
        tick(); check("R4 not taken: entry0", e_rt(SC, 3'd3));
        tick(); check("R4 not taken: branch idle", E_IDLE);
        tick(); check("R2 not taken: fall through, codes 5/6 idle", e_rt(SD, 3'd4));
        tick(); check("R4 not taken: entry3", e_rt(SE, 3'd5));
        tick(); check("R4 not taken: closing jump", E_IDLE);
        stop();
    endtask

    task automatic t_locked();
        start();
        tick(); check("R6 entry0 before write", e_rt(SC, 3'd3));
        cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = w_route(SA, 3'd7);
        tick(); check("R6 branch during write", E_IDLE);
        cfg_we = 1'b0;
        tick(); check("R6 entry2", e_rt(SD, 3'd4));
        tick(); check("R6 entry3", e_rt(SE, 3'd5));
        tick(); check("R6 jump", E_IDLE);
        tick(); check("R6 entry0 unchanged by write while running", e_rt(SC, 3'd3));
        stop();
    endtask

    task automatic t_restart();
        start();
        tick(); check("R7 run: entry0", e_rt(SC, 3'd3));
        tick(); check("R7 run: branch", E_IDLE);
        stop();
        check("R7 stop mid-schedule idle", E_IDLE);
        start();
        check("R7 rearm idle", E_IDLE);
        tick(); check("R7 restart at entry0", e_rt(SC, 3'd3));
        stop();
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 16; i++) begin
            load(4'(i), w_route(pk(i % 5, (i + 1) % 5, (i + 2) % 5, 7, i % 8), 3'(i)));
        end
        start();
        for (int i = 0; i < 16; i++) begin
            tick();
            check("R8 full store walk",
                  e_rt(pk(i % 5, (i + 1) % 5, (i + 2) % 5, 7, i % 8), 3'(i)));
        end
        tick();
        check("R8 wrap from 15 to 0", e_rt(pk(0, 1, 2, 7, 0), 3'd0));
        stop();
    endtask

    initial begin
        tick();
        t_reset();
        t_loop();
        t_stall();
        t_beq();
        t_locked();
        t_restart();
        t_wrap();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule